// File: doc/BRIEF.md
# Packet-Tracking Ancillary Word FIFO

This block buffers ancillary data words between a packet source and a serial inserter. Besides the word storage it keeps a small ring of packet records. Each record holds the number of unread words of one packet and whether that packet's last word has arrived. With these records the FIFO can discard whole packets, hold back reads until a packet is complete, and treat a full record ring the same way as full word storage.

Writers mark the first and last word of each packet. The reader sees a valid word only while insertion is enabled. The whole store, or only the oldest finished packet, can be dropped in two ways: automatically on events in the write stream, or on request once the write side is between packets. A sticky flag records any word that was lost because there was no room.

Top module: `anc_pkt_fifo`

## Requirements
- R1: After reset the FIFO holds no words and no packets. `rd_valid_o`, `overrun_o` and both flush-busy outputs are 0.
- R2: Words leave in the order they were accepted. `rd_valid_o` is 1 only while `ins_en_i` is 1 and `level_o` is non-zero. A word is consumed in a cycle where `rd_valid_o` and `rd_ready_i` are both 1.
- R3: A word with `wr_sop_i`=0 that arrives while no packet is open is ignored. A word with `wr_sop_i`=1 opens a packet, and a word with `wr_eop_i`=1 closes it. A word with both set is a one-word packet.
- R4: While `full_msg_req_i` is 1, `rd_valid_o` stays 0 until the oldest packet's last word has been written. While it is 0, the words of an open packet can be read. Message tracking has no influence on this.
- R5: A start-of-packet word that arrives while MAX_PKTS packets are held is a full condition, in the same way as a word that arrives while `level_o` equals DEPTH.
- R6: On a full condition with no automatic whole-flush armed, the word is dropped and `overrun_o` becomes 1 and stays 1 until reset. The open packet is closed at its truncated length, and its remaining words are ignored.
- R7: On a full condition with `msg_track_i`=1 and `fifo_flush_dyn_i`=1, every stored word is discarded except the words of the packet being written. The incoming word is then accepted if room remains.
- R8: With `msg_track_i`=1 and `msg_flush_dyn_i`=1, each start-of-packet word first discards the oldest complete packet.
- R9: A pulse on `fifo_flush_req_i` while `msg_track_i`=1 raises `fifo_flush_busy_o`. The flush runs in the first cycle in which no packet is open. It empties the FIFO, drops any word offered in that cycle, and then clears the busy flag.
- R10: A pulse on `msg_flush_req_i` while `msg_track_i`=1 raises `msg_flush_busy_o`. The oldest complete packet is discarded in the first cycle with no open packet and `wr_valid_i`=0, and then the busy flag clears.
- R11: With `msg_track_i`=0, flush requests are not latched and the dynamic flush bits have no effect, so a full condition overruns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Write word present |
| wr_data_i | input | DATA_W | Write word |
| wr_sop_i | input | 1 | Word is first of a packet |
| wr_eop_i | input | 1 | Word is last of a packet |
| rd_ready_i | input | 1 | Reader takes the presented word |
| rd_valid_o | output | 1 | Read word available |
| rd_data_o | output | DATA_W | Oldest stored word |
| ins_en_i | input | 1 | Insertion enable, gates reading |
| full_msg_req_i | input | 1 | Only complete packets are readable |
| msg_track_i | input | 1 | Enables all flush functions |
| fifo_flush_dyn_i | input | 1 | Flush all but the current packet on full |
| msg_flush_dyn_i | input | 1 | Drop the oldest packet at each packet start |
| fifo_flush_req_i | input | 1 | Request a whole-store flush |
| msg_flush_req_i | input | 1 | Request an oldest-packet flush |
| fifo_flush_busy_o | output | 1 | Whole-store flush pending |
| msg_flush_busy_o | output | 1 | Oldest-packet flush pending |
| overrun_o | output | 1 | Sticky word-loss flag |
| level_o | output | $clog2(DEPTH+1) | Stored words |
| pkt_cnt_o | output | $clog2(MAX_PKTS+1) | Tracked packets |

## Verification
The bench builds the block with DEPTH=8 and MAX_PKTS=4. With that depth, an eight-word packet fills the word store. With four records, four one-word packets fill the ring. Both full conditions are therefore reached in a few cycles, so the overrun and the automatic keep-current flush can be checked against exact levels. The small ring also makes the oldest-packet flushes easy to observe through the level and packet count.

// File: rtl/anc_fifo_pkg.sv
package anc_fifo_pkg;
  typedef enum logic [1:0] {
    FL_NONE   = 2'd0,
    FL_ALL    = 2'd1,
    FL_OLDEST = 2'd2
  } flush_kind_e;
endpackage

// File: rtl/anc_word_ram.sv
module anc_word_ram #(
  parameter int DATA_W = 10,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/anc_flush_ctl.sv
module anc_flush_ctl
  import anc_fifo_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        msg_track_i,
  input  logic        ff_req_i,
  input  logic        mf_req_i,
  input  logic        open_i,
  input  logic        wr_valid_i,
  output flush_kind_e flush_o,
  output logic        ff_busy_o,
  output logic        mf_busy_o
);
  logic ff_pend_q, mf_pend_q;
  logic ff_exec, mf_exec;

  // whole flush waits for a packet boundary; oldest flush also for an idle write port
  assign ff_exec = ff_pend_q && !open_i && msg_track_i;
  assign mf_exec = mf_pend_q && !ff_exec && !open_i && !wr_valid_i && msg_track_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ff_pend_q <= 1'b0;
      mf_pend_q <= 1'b0;
    end else begin
      ff_pend_q <= (ff_pend_q && !ff_exec) || (ff_req_i && msg_track_i);
      mf_pend_q <= (mf_pend_q && !mf_exec) || (mf_req_i && msg_track_i);
    end
  end

  always_comb begin
    flush_o = FL_NONE;
    if (ff_exec)      flush_o = FL_ALL;
    else if (mf_exec) flush_o = FL_OLDEST;
  end

  assign ff_busy_o = ff_pend_q;
  assign mf_busy_o = mf_pend_q;

  AST_MF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_o == FL_OLDEST && !mf_req_i) |=> !mf_busy_o); // R10
  AST_FF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_o == FL_ALL && !ff_req_i) |=> !ff_busy_o); // R9
endmodule

// File: rtl/anc_pkt_track.sv
module anc_pkt_track
  import anc_fifo_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int MAX_PKTS = 8,
  localparam int AW      = $clog2(DEPTH),
  localparam int CW      = $clog2(DEPTH + 1),
  localparam int PW      = $clog2(MAX_PKTS),
  localparam int NW      = $clog2(MAX_PKTS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_valid_i,
  input  logic          wr_sop_i,
  input  logic          wr_eop_i,
  input  logic          rd_ready_i,
  input  logic          ins_en_i,
  input  logic          full_msg_req_i,
  input  logic          msg_track_i,
  input  logic          fifo_flush_dyn_i,
  input  logic          msg_flush_dyn_i,
  input  flush_kind_e   flush_i,
  output logic          ram_we_o,
  output logic [AW-1:0] ram_waddr_o,
  output logic [AW-1:0] ram_raddr_o,
  output logic          rd_valid_o,
  output logic [CW-1:0] level_o,
  output logic [NW-1:0] pkt_cnt_o,
  output logic          overrun_o,
  output logic          open_o
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [NW-1:0] MAXP_C  = NW'(MAX_PKTS);

  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] head_q, head_d;
  logic [NW-1:0] npk_q, npk_d;
  logic          open_q, open_d, ovr_q, ovr_d;
  logic [CW-1:0] rem_q [MAX_PKTS];
  logic [CW-1:0] rem_d [MAX_PKTS];
  logic          done_q [MAX_PKTS];
  logic          done_d [MAX_PKTS];
  logic          we, rd_ok;

  always_comb begin
    logic [PW-1:0] lst;
    logic          full;
    logic          fl_evt;
    wp_d = wp_q; rp_d = rp_q; cnt_d = cnt_q; head_d = head_q; npk_d = npk_q;
    rem_d = rem_q; done_d = done_q; open_d = open_q; ovr_d = ovr_q;
    we = 1'b0; fl_evt = 1'b0; full = 1'b0; lst = '0;

    case (flush_i)
      FL_ALL: begin
        fl_evt = 1'b1;
        rp_d = wp_q; cnt_d = '0; npk_d = '0;
      end
      FL_OLDEST: begin
        fl_evt = 1'b1;
        if (npk_d != '0 && done_d[head_d]) begin
          rp_d = rp_d + AW'(rem_d[head_d]);
          cnt_d = cnt_d - rem_d[head_d];
          head_d = head_d + PW'(1);
          npk_d = npk_d - NW'(1);
        end
      end
      default: begin
        if (wr_valid_i && (open_d || wr_sop_i)) begin
          // a new start closes an unterminated packet
          if (wr_sop_i && open_d) begin
            lst = head_d + PW'(npk_d - NW'(1));
            if (rem_d[lst] == '0) npk_d = npk_d - NW'(1);
            else done_d[lst] = 1'b1;
            open_d = 1'b0;
          end
          if (wr_sop_i && msg_track_i && msg_flush_dyn_i && npk_d != '0 && done_d[head_d]) begin
            fl_evt = 1'b1;
            rp_d = rp_d + AW'(rem_d[head_d]);
            cnt_d = cnt_d - rem_d[head_d];
            head_d = head_d + PW'(1);
            npk_d = npk_d - NW'(1);
          end
          full = (cnt_d == DEPTH_C) || (wr_sop_i && npk_d == MAXP_C);
          if (full && msg_track_i && fifo_flush_dyn_i) begin
            fl_evt = 1'b1;
            if (open_d) begin
              lst = head_d + PW'(npk_d - NW'(1));
              rp_d = wp_q - AW'(rem_d[lst]);
              cnt_d = rem_d[lst];
              head_d = lst;
              npk_d = NW'(1);
            end else begin
              rp_d = wp_q; cnt_d = '0; npk_d = '0;
            end
            full = (cnt_d == DEPTH_C);
          end
          if (full) begin
            ovr_d = 1'b1;
            if (open_d) begin
              lst = head_d + PW'(npk_d - NW'(1));
              if (rem_d[lst] == '0) npk_d = npk_d - NW'(1);
              else done_d[lst] = 1'b1;
              open_d = 1'b0;
            end
          end else begin
            we = 1'b1;
            wp_d = wp_q + AW'(1);
            cnt_d = cnt_d + CW'(1);
            if (wr_sop_i) begin
              lst = head_d + PW'(npk_d);
              rem_d[lst] = CW'(1);
              done_d[lst] = wr_eop_i;
              npk_d = npk_d + NW'(1);
              open_d = !wr_eop_i;
            end else begin
              lst = head_d + PW'(npk_d - NW'(1));
              rem_d[lst] = rem_d[lst] + CW'(1);
              if (wr_eop_i) begin
                done_d[lst] = 1'b1;
                open_d = 1'b0;
              end
            end
          end
        end
      end
    endcase

    rd_ok = ins_en_i && cnt_q != '0 && (!full_msg_req_i || done_q[head_q]) && !fl_evt;
    if (rd_ok && rd_ready_i) begin
      rp_d = rp_d + AW'(1);
      cnt_d = cnt_d - CW'(1);
      rem_d[head_q] = rem_d[head_q] - CW'(1);
      if (rem_d[head_q] == '0 && done_d[head_q]) begin
        head_d = head_q + PW'(1);
        npk_d = npk_d - NW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0; head_q <= '0; npk_q <= '0;
      open_q <= 1'b0; ovr_q <= 1'b0;
    end else begin
      wp_q <= wp_d; rp_q <= rp_d; cnt_q <= cnt_d; head_q <= head_d; npk_q <= npk_d;
      open_q <= open_d; ovr_q <= ovr_d;
    end
  end

  for (genvar g = 0; g < MAX_PKTS; g++) begin : g_rec
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rem_q[g]  <= '0;
        done_q[g] <= 1'b0;
      end else begin
        rem_q[g]  <= rem_d[g];
        done_q[g] <= done_d[g];
      end
    end
  end

  assign ram_we_o    = we;
  assign ram_waddr_o = wp_q;
  assign ram_raddr_o = rp_q;
  assign rd_valid_o  = rd_ok;
  assign level_o     = cnt_q;
  assign pkt_cnt_o   = npk_q;
  assign overrun_o   = ovr_q;
  assign open_o      = open_q;

  AST_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= DEPTH_C); // R2
  AST_PKT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    npk_q <= MAXP_C); // R5
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o); // R6
  AST_FF_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i == FL_ALL) |=> (level_o == '0)); // R9
  AST_NO_RD_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ins_en_i && $past(ins_en_i) == 1'b0) |=> $stable(ram_raddr_o) || $past(flush_i) != FL_NONE || $past(we)); // R2
endmodule

// File: rtl/anc_pkt_fifo.sv
module anc_pkt_fifo
  import anc_fifo_pkg::*;
#(
  parameter int DATA_W   = 10,
  parameter int DEPTH    = 16,
  parameter int MAX_PKTS = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_valid_i,
  input  logic [DATA_W-1:0]              wr_data_i,
  input  logic                           wr_sop_i,
  input  logic                           wr_eop_i,
  input  logic                           rd_ready_i,
  output logic                           rd_valid_o,
  output logic [DATA_W-1:0]              rd_data_o,
  input  logic                           ins_en_i,
  input  logic                           full_msg_req_i,
  input  logic                           msg_track_i,
  input  logic                           fifo_flush_dyn_i,
  input  logic                           msg_flush_dyn_i,
  input  logic                           fifo_flush_req_i,
  input  logic                           msg_flush_req_i,
  output logic                           fifo_flush_busy_o,
  output logic                           msg_flush_busy_o,
  output logic                           overrun_o,
  output logic [$clog2(DEPTH+1)-1:0]     level_o,
  output logic [$clog2(MAX_PKTS+1)-1:0]  pkt_cnt_o
);
  localparam int AW = $clog2(DEPTH);

  flush_kind_e   flush;
  logic          open, ram_we;
  logic [AW-1:0] waddr, raddr;

  anc_flush_ctl u_flush (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .msg_track_i (msg_track_i),
    .ff_req_i    (fifo_flush_req_i),
    .mf_req_i    (msg_flush_req_i),
    .open_i      (open),
    .wr_valid_i  (wr_valid_i),
    .flush_o     (flush),
    .ff_busy_o   (fifo_flush_busy_o),
    .mf_busy_o   (msg_flush_busy_o)
  );

  anc_pkt_track #(.DEPTH(DEPTH), .MAX_PKTS(MAX_PKTS)) u_track (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .wr_valid_i       (wr_valid_i),
    .wr_sop_i         (wr_sop_i),
    .wr_eop_i         (wr_eop_i),
    .rd_ready_i       (rd_ready_i),
    .ins_en_i         (ins_en_i),
    .full_msg_req_i   (full_msg_req_i),
    .msg_track_i      (msg_track_i),
    .fifo_flush_dyn_i (fifo_flush_dyn_i),
    .msg_flush_dyn_i  (msg_flush_dyn_i),
    .flush_i          (flush),
    .ram_we_o         (ram_we),
    .ram_waddr_o      (waddr),
    .ram_raddr_o      (raddr),
    .rd_valid_o       (rd_valid_o),
    .level_o          (level_o),
    .pkt_cnt_o        (pkt_cnt_o),
    .overrun_o        (overrun_o),
    .open_o           (open)
  );

  anc_word_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk_i   (clk_i),
    .we_i    (ram_we),
    .waddr_i (waddr),
    .wdata_i (wr_data_i),
    .raddr_i (raddr),
    .rdata_o (rd_data_o)
  );
endmodule

// File: tb/sim_anc_pkt_fifo.sv
`timescale 1ns/1ps
module sim_anc_pkt_fifo;
  localparam int DATA_W = 10;
  localparam int DEPTH = 8;
  localparam int MAX_PKTS = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_valid = 0, wr_sop = 0, wr_eop = 0, rd_ready = 0;
  logic [DATA_W-1:0] wr_data = '0;
  logic ins_en = 0, full_msg = 0, track = 0, ff_dyn = 0, mf_dyn = 0, ff_req = 0, mf_req = 0;
  logic rd_valid, ff_busy, mf_busy, ovr;
  logic [DATA_W-1:0] rd_data;
  logic [$clog2(DEPTH+1)-1:0] level;
  logic [$clog2(MAX_PKTS+1)-1:0] pkts;
  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  anc_pkt_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .MAX_PKTS(MAX_PKTS)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .wr_sop_i(wr_sop), .wr_eop_i(wr_eop),
    .rd_ready_i(rd_ready), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .ins_en_i(ins_en), .full_msg_req_i(full_msg), .msg_track_i(track),
    .fifo_flush_dyn_i(ff_dyn), .msg_flush_dyn_i(mf_dyn),
    .fifo_flush_req_i(ff_req), .msg_flush_req_i(mf_req),
    .fifo_flush_busy_o(ff_busy), .msg_flush_busy_o(mf_busy),
    .overrun_o(ovr), .level_o(level), .pkt_cnt_o(pkts)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 0; wr_valid = 0; wr_sop = 0; wr_eop = 0; rd_ready = 0;
    ins_en = 0; full_msg = 0; track = 0; ff_dyn = 0; mf_dyn = 0; ff_req = 0; mf_req = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
  endtask

  task automatic wr(input int d, input bit s, input bit e);
    @(negedge clk);
    wr_valid = 1; wr_data = DATA_W'(d); wr_sop = s; wr_eop = e;
    @(negedge clk);
    wr_valid = 0; wr_sop = 0; wr_eop = 0;
  endtask

  task automatic pop(input string req, input int exp);
    chk({req, " valid"}, int'(rd_valid), 1);
    chk({req, " data"}, int'(rd_data), exp);
    rd_ready = 1;
    @(negedge clk);
    rd_ready = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 level", int'(level), 0);
    chk("R1 pkts", int'(pkts), 0);
    chk("R1 valid", int'(rd_valid), 0);
    chk("R1 overrun", int'(ovr), 0);
    chk("R1 busy", int'(ff_busy) + int'(mf_busy), 0);
  endtask

  task automatic t_order();
    do_reset();
    wr(16'h3ff, 0, 0);
    chk("R3 stray word", int'(level), 0);
    wr(1, 1, 0); wr(2, 0, 0); wr(3, 0, 1);
    chk("R3 level", int'(level), 3);
    chk("R3 pkts", int'(pkts), 1);
    chk("R2 gated", int'(rd_valid), 0);
    ins_en = 1;
    @(negedge clk);
    pop("R2 w0", 1); pop("R2 w1", 2); pop("R2 w2", 3);
    chk("R2 drained", int'(level), 0);
    chk("R2 valid low", int'(rd_valid), 0);
  endtask

  task automatic t_fullmsg();
    do_reset();
    full_msg = 1; ins_en = 1;
    wr(5, 1, 0);
    chk("R4 held open", int'(rd_valid), 0);
    wr(6, 0, 0);
    chk("R4 held open2", int'(rd_valid), 0);
    wr(7, 0, 1);
    pop("R4 a", 5); pop("R4 b", 6); pop("R4 c", 7);
    full_msg = 0;
    wr(8, 1, 0);
    pop("R4 partial", 8);
    chk("R4 open record kept", int'(pkts), 1);
    wr(9, 0, 1);
    pop("R4 tail", 9);
    chk("R4 record freed", int'(pkts), 0);
  endtask

  task automatic t_overrun();
    do_reset();
    for (int i = 0; i < MAX_PKTS; i++) wr(10 + i, 1, 1);
    chk("R5 pkts", int'(pkts), MAX_PKTS);
    wr(14, 1, 1);
    chk("R5 dropped", int'(level), MAX_PKTS);
    chk("R5 overrun", int'(ovr), 1);
    ins_en = 1;
    @(negedge clk);
    for (int i = 0; i < MAX_PKTS; i++) pop("R5 drain", 10 + i);
    ins_en = 0;
    wr(20, 1, 0);
    for (int i = 1; i < DEPTH; i++) wr(20 + i, 0, 0);
    chk("R6 full", int'(level), DEPTH);
    wr(28, 0, 0);
    wr(29, 0, 1);
    chk("R6 level", int'(level), DEPTH);
    chk("R6 pkts", int'(pkts), 1);
    ins_en = 1;
    @(negedge clk);
    for (int i = 0; i < DEPTH; i++) pop("R6 data", 20 + i);
    chk("R6 pkts after", int'(pkts), 0);
    chk("R6 sticky", int'(ovr), 1);
  endtask

  task automatic t_dyn_ff();
    do_reset();
    track = 1; ff_dyn = 1;
    wr(1, 1, 0); wr(2, 0, 1);
    wr(3, 1, 0);
    for (int i = 4; i <= 8; i++) wr(i, 0, 0);
    chk("R7 full", int'(level), DEPTH);
    wr(9, 0, 0);
    chk("R7 level", int'(level), 7);
    chk("R7 pkts", int'(pkts), 1);
    chk("R7 no overrun", int'(ovr), 0);
    ins_en = 1;
    @(negedge clk);
    for (int i = 3; i <= 9; i++) pop("R7 kept", i);
    do_reset();
    ff_dyn = 1;
    wr(1, 1, 0);
    for (int i = 2; i <= 9; i++) wr(i, 0, 0);
    chk("R11 overrun", int'(ovr), 1);
    chk("R11 level", int'(level), DEPTH);
  endtask

  task automatic t_dyn_mf();
    do_reset();
    track = 1; mf_dyn = 1;
    wr(1, 1, 0); wr(2, 0, 1);
    wr(3, 1, 1);
    chk("R8 level", int'(level), 1);
    chk("R8 pkts", int'(pkts), 1);
    ins_en = 1;
    @(negedge clk);
    pop("R8 newest", 3);
    do_reset();
    mf_dyn = 1;
    wr(1, 1, 0); wr(2, 0, 1); wr(3, 1, 1);
    chk("R11 no drop", int'(level), 3);
  endtask

  task automatic t_stat_ff();
    do_reset();
    track = 1;
    wr(1, 1, 0); wr(2, 0, 1); wr(3, 1, 0);
    @(negedge clk); ff_req = 1;
    @(negedge clk); ff_req = 0;
    @(negedge clk);
    chk("R9 waits", int'(ff_busy), 1);
    chk("R9 kept", int'(level), 3);
    wr(4, 0, 1);
    @(negedge clk);
    chk("R9 emptied", int'(level), 0);
    chk("R9 self clear", int'(ff_busy), 0);
    wr(5, 1, 0); wr(6, 0, 1);
    @(negedge clk); ff_req = 1;
    @(negedge clk); ff_req = 0;
    wr_valid = 1; wr_data = 10'd7; wr_sop = 1; wr_eop = 1;
    @(negedge clk);
    wr_valid = 0; wr_sop = 0; wr_eop = 0;
    chk("R9 blocked", int'(level), 0);
    chk("R9 done", int'(ff_busy), 0);
    track = 0;
    wr(8, 1, 1);
    @(negedge clk); ff_req = 1;
    @(negedge clk); ff_req = 0;
    @(negedge clk);
    chk("R11 req ignored", int'(ff_busy), 0);
    chk("R11 level", int'(level), 1);
  endtask

  task automatic t_stat_mf();
    do_reset();
    track = 1;
    wr(1, 1, 0); wr(2, 0, 1); wr(3, 1, 0); wr(4, 0, 1);
    @(negedge clk); mf_req = 1;
    @(negedge clk); mf_req = 0;
    @(negedge clk);
    chk("R10 level", int'(level), 2);
    chk("R10 pkts", int'(pkts), 1);
    chk("R10 clear", int'(mf_busy), 0);
    wr(5, 1, 0);
    @(negedge clk); mf_req = 1;
    @(negedge clk); mf_req = 0;
    @(negedge clk);
    chk("R10 waits", int'(mf_busy), 1);
    chk("R10 kept", int'(level), 3);
    wr(6, 0, 1);
    @(negedge clk);
    chk("R10 late level", int'(level), 2);
    chk("R10 late clear", int'(mf_busy), 0);
    ins_en = 1;
    @(negedge clk);
    pop("R10 survivor", 5);
    pop("R10 survivor2", 6);
  endtask

  initial begin
    t_reset();
    t_order();
    t_fullmsg();
    t_overrun();
    t_dyn_ff();
    t_dyn_mf();
    t_stat_ff();
    t_stat_mf();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule